// File: doc/BRIEF.md
# Keyed SHA-1 Authentication Code Engine

This block produces a 160-bit message authentication code. It runs the SHA-1 compression function over one 512-bit block. The block is assembled from a 64-bit secret key, a 64-bit device identifier, a 64-bit challenge, a 256-bit page of user data and a 64-bit fixed constant. The constant takes the place of ordinary SHA-1 length padding, so the block has no padding logic. Because the key is only 64 of the 512 bits, an observer who knows the public fields still has to search the full key space to reproduce a code.

A host presents all fields in parallel and pulses `start_i`. The engine captures the fields and runs eighty rounds, one per clock. It then adds the working variables to the standard initial chaining values and raises `done_o` for one cycle, with the digest on `digest_o`. The controller has four states. `IDLE` waits for start. `ROUND` performs the eighty rounds. `SUM` forms the digest. `DONE` signals completion. The transitions are IDLE→ROUND on an accepted start, ROUND→ROUND while rounds remain, ROUND→SUM after the eightieth round, SUM→DONE, and DONE→IDLE.

Top module: `keyed_mac_core`

## Requirements
- R1: While reset is low, and in the first cycle after it, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R2: The hashed block is read as sixteen big-endian 32-bit words, word 0 first. Words 0–1 hold `key_i` (bits 63:32 first). Words 2–9 hold `page_i` (bits 255:224 first). Words 10–11 hold `dev_id_i`. Words 12–13 hold `chal_i`. Words 14–15 hold the parameter `PAD_CONST`.
- R3: `digest_o` is the SHA-1 compression of that block, starting from the standard initial chaining values and with those values added at the end. The first word (A) sits in bits 159:128 and the last word (E) in bits 31:0.
- R4: A start accepted in IDLE makes `busy_o` high on the following cycle. `busy_o` then stays high for exactly 81 cycles.
- R5: `done_o` goes high in the cycle after the 82nd rising edge, counting the edge that sampled `start_i` as the first. It stays high for exactly one cycle, and `busy_o` is low while it is high.
- R6: A start seen while busy or while `done_o` is high is ignored. The running computation is neither restarted nor lengthened, and only one `done_o` pulse occurs.
- R7: The field inputs are captured at the edge that accepts start. Changing them afterwards has no effect on the digest of that run.
- R8: `digest_o` changes only on the edge that raises `done_o`, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled in IDLE |
| key_i | input | 64 | Secret key |
| page_i | input | 256 | User data page |
| dev_id_i | input | 64 | Device identifier |
| chal_i | input | 64 | Challenge value |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| digest_o | output | 160 | Authentication code, A word most significant |

## Verification
The main function is tried first with a known-answer block: the key field and the constant reproduce a standard three-byte message, which pins down word order and the final addition independently of the bench model. All-zero and all-ones fields expose stuck or inverted schedule terms. Random fields, including runs that differ in a single key bit, check the full round and constant selection against a bench reference that expands all eighty schedule words directly. A run disturbed by extra start pulses and changing fields separates true input capture and start rejection from a design that restarts or re-reads its inputs.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int WORD_W   = 32;
    localparam int BLOCK_W  = 512;
    localparam int N_WORDS  = BLOCK_W / WORD_W;
    localparam int N_ROUNDS = 80;
    localparam int RND_W    = $clog2(N_ROUNDS);
    localparam int IDX_W    = $clog2(N_WORDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } vars_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUND,
        ST_SUM,
        ST_DONE
    } state_e;

    localparam vars_t CHAIN_INIT = vars_t'({32'h67452301, 32'hEFCDAB89,
                                            32'h98BADCFE, 32'h10325476,
                                            32'hC3D2E1F0});

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t mix_f(input logic [RND_W-1:0] t,
                                    input word_t b, input word_t c, input word_t d);
        if (t < 20)      return (b & c) | (~b & d);
        else if (t < 40) return b ^ c ^ d;
        else if (t < 60) return (b & c) | (b & d) | (c & d);
        else             return b ^ c ^ d;
    endfunction

    function automatic word_t round_k(input logic [RND_W-1:0] t);
        if (t < 20)      return 32'h5A827999;
        else if (t < 40) return 32'h6ED9EBA1;
        else if (t < 60) return 32'h8F1BBCDC;
        else             return 32'hCA62C1D6;
    endfunction

endpackage

// File: rtl/mac_schedule.sv
module mac_schedule
    import mac_pkg::*;
(
    input  logic                 clk,
    input  logic                 load,
    input  logic [BLOCK_W-1:0]   block,
    input  logic                 advance,
    input  logic [RND_W-1:0]     rnd,
    output word_t                w_cur
);

    word_t ring_q [N_WORDS];

    logic [IDX_W-1:0] i_now;
    logic [IDX_W-1:0] i_m3;
    logic [IDX_W-1:0] i_m8;
    logic [IDX_W-1:0] i_m14;

    // Offsets modulo 16: t-3 = t+13, t-8 = t+8, t-14 = t+2, t-16 = t
    always_comb begin
        i_now = rnd[IDX_W-1:0];
        i_m3  = i_now + IDX_W'(13);
        i_m8  = i_now + IDX_W'(8);
        i_m14 = i_now + IDX_W'(2);
    end

    always_comb begin
        if (rnd < RND_W'(N_WORDS))
            w_cur = ring_q[i_now];
        else
            w_cur = rotl(ring_q[i_m3] ^ ring_q[i_m8] ^ ring_q[i_m14] ^ ring_q[i_now], 1);
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < N_WORDS; i++)
                ring_q[i] <= block[BLOCK_W-1-WORD_W*i -: WORD_W];
        end else if (advance) begin
            ring_q[i_now] <= w_cur;
        end
    end

endmodule

// File: rtl/mac_round.sv
module mac_round
    import mac_pkg::*;
(
    input  vars_t             cur,
    input  word_t             w_cur,
    input  logic [RND_W-1:0]  rnd,
    output vars_t             nxt
);

    word_t temp;

    always_comb begin
        temp  = rotl(cur.a, 5) + mix_f(rnd, cur.b, cur.c, cur.d)
              + cur.e + round_k(rnd) + w_cur;
        nxt.a = temp;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              load,
    output logic              advance,
    output logic              sum_en,
    output logic              busy,
    output logic              done,
    output logic [RND_W-1:0]  rnd
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);

    state_e state_q;
    state_e state_d;
    logic [RND_W-1:0] rnd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ROUND;
            ST_ROUND: if (rnd_q == LAST_RND) state_d = ST_SUM;
            ST_SUM:   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                rnd_q <= '0;
            else if (state_q == ST_ROUND)
                rnd_q <= rnd_q + 1'b1;
        end
    end

    always_comb begin
        load    = 1'b0;
        advance = 1'b0;
        sum_en  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_ROUND: begin
                advance = 1'b1;
                busy    = 1'b1;
            end
            ST_SUM: begin
                sum_en = 1'b1;
                busy   = 1'b1;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign rnd = rnd_q;

endmodule

// File: rtl/keyed_mac_core.sv
module keyed_mac_core
    import mac_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int ID_W   = 64,
    parameter int CHAL_W = 64,
    parameter int CONST_W = 64,
    parameter int PAGE_W = BLOCK_W - KEY_W - ID_W - CHAL_W - CONST_W,
    parameter logic [CONST_W-1:0] PAD_CONST = 64'h0000_0000_0000_0018
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [ID_W-1:0]    dev_id_i,
    input  logic [CHAL_W-1:0]  chal_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [5*WORD_W-1:0] digest_o
);

    localparam int DIG_WORDS = 5;

    logic               load;
    logic               advance;
    logic               sum_en;
    logic [RND_W-1:0]   rnd;
    logic [BLOCK_W-1:0] block;
    word_t              w_cur;
    vars_t              vars_q;
    vars_t              vars_nxt;
    logic [5*WORD_W-1:0] sum_w;
    logic [5*WORD_W-1:0] digest_q;

    assign block = {key_i, page_i, dev_id_i, chal_i, PAD_CONST};

    mac_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .load    (load),
        .advance (advance),
        .sum_en  (sum_en),
        .busy    (busy_o),
        .done    (done_o),
        .rnd     (rnd)
    );

    mac_schedule u_sched (
        .clk     (clk),
        .load    (load),
        .block   (block),
        .advance (advance),
        .rnd     (rnd),
        .w_cur   (w_cur)
    );

    mac_round u_round (
        .cur   (vars_q),
        .w_cur (w_cur),
        .rnd   (rnd),
        .nxt   (vars_nxt)
    );

    always_ff @(posedge clk) begin
        if (load)
            vars_q <= CHAIN_INIT;
        else if (advance)
            vars_q <= vars_nxt;
    end

    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_sum
        assign sum_w[g*WORD_W +: WORD_W] = vars_q[g*WORD_W +: WORD_W]
                                         + CHAIN_INIT[g*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            digest_q <= '0;
        else if (sum_en)
            digest_q <= sum_w;
    end

    assign digest_o = digest_q;

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int BUSY_CYCLES = 81
)(
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [159:0] digest_o
);

    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len <= '0;
        else if (busy_o)
            busy_len <= busy_len + 1'b1;
        else
            busy_len <= '0;
    end

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r4_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_len == 8'(BUSY_CYCLES)));

    a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    a_r8_digest_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digest_o) |-> done_o);

endmodule

bind keyed_mac_core mac_checker i_mac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .digest_o (digest_o)
);

// File: tb/test_keyed_mac_core.sv
module test_keyed_mac_core;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 82;
    localparam logic [63:0] PAD = 64'h0000_0000_0000_0018;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  key_i = '0;
    logic [255:0] page_i = '0;
    logic [63:0]  dev_id_i = '0;
    logic [63:0]  chal_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [159:0] digest_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    keyed_mac_core #(.PAD_CONST(PAD)) i_keyed_mac_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .key_i    (key_i),
        .page_i   (page_i),
        .dev_id_i (dev_id_i),
        .chal_i   (chal_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .digest_o (digest_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Reference: full 80-word expansion, R2 layout, R3 output order
    function automatic logic [159:0] ref_mac(input logic [63:0] k, input logic [255:0] p,
                                             input logic [63:0] id, input logic [63:0] ch);
        logic [511:0] blk;
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, kk, tmp;
        blk = {k, p, id, ch, PAD};
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE;
        d = 32'h10325476; e = 32'hC3D2E1F0;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          kk = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   kk = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); kk = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   kk = 32'hCA62C1D6; end
            tmp = rl(a, 5) + f + e + kk + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = tmp;
        end
        return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
                d + 32'h10325476, e + 32'hC3D2E1F0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Runs one computation; disturb adds start pulses and field changes mid-run
    task automatic run(input logic [159:0] exp, input bit disturb, input string tag);
        int cnt;
        bit busy_bad;
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        cnt = 1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R4 busy after start", {159'b0, busy_o}, 160'd1);
        busy_bad = 1'b0;
        while (done_o !== 1'b1 && cnt < 300) begin
            if (disturb && cnt == 30) begin
                start_i  = 1'b1;
                key_i    = ~key_i;
                page_i   = {$urandom, $urandom, $urandom, $urandom,
                            $urandom, $urandom, $urandom, $urandom};
                dev_id_i = {$urandom, $urandom};
                chal_i   = {$urandom, $urandom};
            end
            if (disturb && cnt == 36) start_i = 1'b0;
            if (busy_o !== 1'b1) busy_bad = 1'b1;
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(!busy_bad, "R4 busy held", {159'b0, busy_bad}, 160'd0);
        check(cnt == LATENCY, disturb ? "R6 latency under extra start" : "R5 latency",
              160'(cnt), 160'(LATENCY));
        check(busy_o === 1'b0, "R5 busy low with done", {159'b0, busy_o}, 160'd0);
        check(digest_o === exp, tag, digest_o, exp);
        @(negedge clk);
        check(done_o === 1'b0, "R5 done single cycle", {159'b0, done_o}, 160'd0);
    endtask

    initial begin
        logic [159:0] exp;
        logic [159:0] prev;
        bit extra_done;
        bit changed;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && digest_o === '0,
              "R1 reset state", digest_o, 160'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && digest_o === '0,
              "R1 after reset", {busy_o, done_o, digest_o[157:0]}, 160'd0);

        // Known answer: words 0..15 form a standard padded three-byte message
        key_i = 64'h6162638000000000; page_i = '0; dev_id_i = '0; chal_i = '0;
        run(160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, 1'b0, "R2 R3 known vector");

        key_i = '0; page_i = '0; dev_id_i = '0; chal_i = '0;
        run(ref_mac(key_i, page_i, dev_id_i, chal_i), 1'b0, "R3 all zero fields");

        key_i = '1; page_i = '1; dev_id_i = '1; chal_i = '1;
        run(ref_mac(key_i, page_i, dev_id_i, chal_i), 1'b0, "R3 all ones fields");

        for (int n = 0; n < 8; n++) begin
            key_i    = {$urandom, $urandom};
            page_i   = {$urandom, $urandom, $urandom, $urandom,
                        $urandom, $urandom, $urandom, $urandom};
            dev_id_i = {$urandom, $urandom};
            chal_i   = {$urandom, $urandom};
            run(ref_mac(key_i, page_i, dev_id_i, chal_i), 1'b0, "R2 R3 random fields");
            prev = digest_o;
            key_i[$urandom_range(63, 0)] ^= 1'b1;
            exp = ref_mac(key_i, page_i, dev_id_i, chal_i);
            run(exp, 1'b0, "R3 single key bit flip");
            check(digest_o !== prev, "R3 key bit changes digest", digest_o, prev);
        end

        // Extra start pulses and changing fields during a run
        key_i    = {$urandom, $urandom};
        page_i   = {$urandom, $urandom, $urandom, $urandom,
                    $urandom, $urandom, $urandom, $urandom};
        dev_id_i = 64'h0123_4567_89AB_CDEF;
        chal_i   = {$urandom, $urandom};
        exp = ref_mac(key_i, page_i, dev_id_i, chal_i);
        run(exp, 1'b1, "R6 R7 digest of captured fields");

        // No further done and a stable digest while idle
        extra_done = 1'b0;
        changed = 1'b0;
        key_i = ~key_i;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (done_o === 1'b1) extra_done = 1'b1;
            if (digest_o !== exp) changed = 1'b1;
        end
        check(!extra_done, "R6 single done pulse", {159'b0, extra_done}, 160'd0);
        check(!changed, "R8 digest holds", digest_o, exp);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule